// File: doc/BRIEF.md
# Two-Register Stack ALU Datapath

This block is the execution datapath of a stack-oriented processor. The two topmost stack entries are held in registers: TOS is the top and NOS sits beneath it. Entries below NOS spill into an on-chip stack RAM, which is addressed through a stack pointer. An external decoder drives every select and enable line in the same cycle that the line takes effect. The block holds no control state of its own.

In each cycle the datapath can do the following:

- form the sum or the difference of TOS and NOS;
- apply a bitwise operation, or shift NOS by an amount held in TOS;
- load TOS from any of several sources: the arithmetic result, the logic result, the shift result, the stack RAM, the I/O input word, or an internal pointer register;
- push TOS down into NOS, or refill NOS from the RAM;
- step, hold or reload the stack pointer.

Four flags describe the current TOS and NOS.

Top module: `stk_datapath`

## Requirements
- R1: When `op_sub`=0 the arithmetic result is TOS+NOS. When `op_sub`=1 it is NOS−TOS. Both wrap modulo 2^DW. TOS takes this result when `a_src`=0 and `a_we`=1.
- R2: TOS changes only at a clock edge where `a_we`=1. With `a_src`=1 it takes the load-mux output.
- R3: NOS changes only at a clock edge where `b_we`=1. It takes the old TOS when `b_src`=0, and the registered RAM read data when `b_src`=1.
- R4: `log_op` selects the logic result: 0 gives NOS, 1 gives TOS AND NOS, 2 gives TOS OR NOS, 3 gives TOS XOR NOS.
- R5: The shifter shifts NOS by TOS[log2(DW)-1:0], so higher TOS bits are ignored. `shf_op` selects the kind of shift: 0 and 3 are logical right shifts, 1 is a left shift, 2 is an arithmetic right shift.
- R6: `ld_src` selects the load-mux source: 0 is the logic result, 1 is the shifter, 2 is the RAM read data, 3 is `io_rdata`, 4 is the register source. Codes 5 to 7 select the logic result.
- R7: `reg_src` selects the register source: 0 and 3 give SP, 1 gives VP, 2 gives `bcpc_in`. Each is zero-extended to DW bits.
- R8: `sp_op` controls the stack pointer: 0 holds SP, 1 loads TOS[AW-1:0], 2 decrements SP, 3 increments SP. The increment and decrement wrap modulo 2^AW.
- R9: `flag_zero` is 1 exactly when TOS is 0. `flag_neg` equals the sign bit of TOS.
- R10: `flag_eq` is 1 when TOS equals NOS. `flag_lt` is 1 when NOS is less than TOS as signed numbers.
- R11: When `ram_we`=1, the stack RAM stores NOS at `ram_dir_addr` if `ram_wr_dir`=1, and at SP+1 otherwise. When `ram_we`=0 nothing is written. The read address is `ram_dir_addr` if `ram_rd_dir`=1 and SP otherwise. The read data appears one cycle after the address.
- R12: VP loads TOS[AW-1:0] only at an edge where `vp_we`=1.
- R13: While reset is asserted, TOS, NOS and VP are 0 and SP is SP_INIT (64). The internal release follows the deassertion of `rst_ni` by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_sub | input | 1 | Arithmetic select: 0 for add, 1 for subtract |
| a_src | input | 1 | TOS source: 0 for arithmetic result, 1 for load mux |
| a_we | input | 1 | TOS write enable |
| b_src | input | 1 | NOS source: 0 for old TOS, 1 for RAM read data |
| b_we | input | 1 | NOS write enable |
| log_op | input | 2 | Logic operation select |
| shf_op | input | 2 | Shift kind select |
| ld_src | input | 3 | Load mux select |
| reg_src | input | 2 | Register source select |
| sp_op | input | 2 | Stack pointer update select |
| vp_we | input | 1 | VP write enable |
| ram_we | input | 1 | Stack RAM write enable |
| ram_wr_dir | input | 1 | Use the direct address for the write |
| ram_rd_dir | input | 1 | Use the direct address for the read |
| ram_dir_addr | input | AW | Direct RAM address |
| io_rdata | input | DW | I/O input word |
| bcpc_in | input | PCW | Bytecode program counter |
| tos | output | DW | Top of stack |
| nos | output | DW | Next on stack |
| flag_zero | output | 1 | TOS is zero |
| flag_neg | output | 1 | TOS is negative |
| flag_eq | output | 1 | TOS equals NOS |
| flag_lt | output | 1 | NOS is less than TOS, signed |

## Verification
The assertions assume that every select and enable is a known value at each clock edge after the internal reset releases. They also assume that a pop which refills NOS from the RAM comes at least one cycle after the read address settles on the wanted word. The stimulus drives every control from an all-idle default, one cycle after the clock edge. It inserts an idle cycle between a spill and the pop that reads the spilled word back, and it reads directly addressed words only after writing them.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [2:0] LD_LOGIC = 3'd0;
  localparam logic [2:0] LD_SHIFT = 3'd1;
  localparam logic [2:0] LD_RAM   = 3'd2;
  localparam logic [2:0] LD_IO    = 3'd3;
  localparam logic [2:0] LD_REG   = 3'd4;

  localparam logic [1:0] RS_SP    = 2'd0;
  localparam logic [1:0] RS_VP    = 2'd1;
  localparam logic [1:0] RS_PC    = 2'd2;

  localparam logic [1:0] SP_HOLD  = 2'd0;
  localparam logic [1:0] SP_LOAD  = 2'd1;
  localparam logic [1:0] SP_DEC   = 2'd2;
  localparam logic [1:0] SP_INC   = 2'd3;

  localparam logic [1:0] LG_PASS  = 2'd0;
  localparam logic [1:0] LG_AND   = 2'd1;
  localparam logic [1:0] LG_OR    = 2'd2;
  localparam logic [1:0] LG_XOR   = 2'd3;

  localparam logic [1:0] SH_LEFT  = 2'd1;
  localparam logic [1:0] SH_ARITH = 2'd2;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          op_sub,
  input  logic [1:0]    log_op,
  input  logic [1:0]    shf_op,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] log_res,
  output logic [DW-1:0] shf_res
);
  import stk_pkg::*;

  localparam int SW = $clog2(DW);

  logic [SW-1:0] amt;
  logic          fill;
  logic [DW-1:0] rstage [SW+1];
  logic [DW-1:0] lstage [SW+1];

  // arithmetic: NOS - TOS for subtract (R1)
  assign sum = op_sub ? (b - a) : (a + b);

  always_comb begin
    unique case (log_op)
      LG_PASS: log_res = b;
      LG_AND:  log_res = a & b;
      LG_OR:   log_res = a | b;
      default: log_res = a ^ b;
    endcase
  end

  // barrel shifter, one stage per amount bit (R5)
  assign amt  = a[SW-1:0];
  assign fill = (shf_op == SH_ARITH) ? b[DW-1] : 1'b0;
  assign rstage[0] = b;
  assign lstage[0] = b;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign rstage[i+1] = amt[i] ? {{SH{fill}}, rstage[i][DW-1:SH]} : rstage[i];
    assign lstage[i+1] = amt[i] ? {lstage[i][DW-1-SH:0], {SH{1'b0}}} : lstage[i];
  end

  assign shf_res = (shf_op == SH_LEFT) ? lstage[SW] : rstage[SW];
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          AW      = 8,
  parameter logic [AW-1:0] SP_INIT = AW'(64)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sp_op,
  input  logic          vp_we,
  input  logic [AW-1:0] a_low,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] vp
);
  import stk_pkg::*;

  logic [AW-1:0] sp_d;
  logic [AW-1:0] vp_d;

  always_comb begin
    unique case (sp_op)
      SP_HOLD: sp_d = sp;
      SP_LOAD: sp_d = a_low;
      SP_DEC:  sp_d = sp - AW'(1);
      default: sp_d = sp + AW'(1);
    endcase
    vp_d = vp_we ? a_low : vp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= SP_INIT;
      vp <= '0;
    end else begin
      sp <= sp_d;
      vp <= vp_d;
    end
  end

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sp_op == SP_HOLD |=> $stable(sp)); // R8
  AST_SP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    sp_op == SP_INC |=> sp == $past(sp) + AW'(1)); // R8
  AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    sp_op == SP_DEC |=> sp == $past(sp) - AW'(1)); // R8
  AST_VP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vp_we |=> $stable(vp)); // R12
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read returns the word held before a same-cycle write (R11)
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stk_datapath.sv
module stk_datapath #(
  parameter int            DW      = 32,
  parameter int            AW      = 8,
  parameter int            PCW     = 10,
  parameter logic [AW-1:0] SP_INIT = AW'(64)
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           op_sub,
  input  logic           a_src,
  input  logic           a_we,
  input  logic           b_src,
  input  logic           b_we,
  input  logic [1:0]     log_op,
  input  logic [1:0]     shf_op,
  input  logic [2:0]     ld_src,
  input  logic [1:0]     reg_src,
  input  logic [1:0]     sp_op,
  input  logic           vp_we,
  input  logic           ram_we,
  input  logic           ram_wr_dir,
  input  logic           ram_rd_dir,
  input  logic [AW-1:0]  ram_dir_addr,
  input  logic [DW-1:0]  io_rdata,
  input  logic [PCW-1:0] bcpc_in,
  output logic [DW-1:0]  tos,
  output logic [DW-1:0]  nos,
  output logic           flag_zero,
  output logic           flag_neg,
  output logic           flag_eq,
  output logic           flag_lt
);
  import stk_pkg::*;

  logic [1:0]    rst_sync;
  logic          rst_n;
  logic [DW-1:0] tos_q, nos_q, tos_d, nos_d;
  logic [DW-1:0] sum, log_res, shf_res, ld_val, reg_val, ram_rdata;
  logic [AW-1:0] sp, vp, ram_waddr, ram_raddr;

  // asynchronous assertion, synchronous release (R13)
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  stk_alu #(.DW(DW)) u_alu (
    .a(tos_q), .b(nos_q), .op_sub(op_sub), .log_op(log_op),
    .shf_op(shf_op), .sum(sum), .log_res(log_res), .shf_res(shf_res)
  );

  stk_ptr #(.AW(AW), .SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sp_op(sp_op), .vp_we(vp_we),
    .a_low(tos_q[AW-1:0]), .sp(sp), .vp(vp)
  );

  assign ram_waddr = ram_wr_dir ? ram_dir_addr : (sp + AW'(1));
  assign ram_raddr = ram_rd_dir ? ram_dir_addr : sp;

  stk_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(nos_q),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  always_comb begin
    unique case (reg_src)
      RS_VP:   reg_val = DW'(vp);
      RS_PC:   reg_val = DW'(bcpc_in);
      default: reg_val = DW'(sp);
    endcase
    case (ld_src)
      LD_SHIFT: ld_val = shf_res;
      LD_RAM:   ld_val = ram_rdata;
      LD_IO:    ld_val = io_rdata;
      LD_REG:   ld_val = reg_val;
      default:  ld_val = log_res;
    endcase
    tos_d = a_src ? ld_val : sum;
    nos_d = b_src ? ram_rdata : tos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
      nos_q <= '0;
    end else begin
      if (a_we) tos_q <= tos_d;
      if (b_we) nos_q <= nos_d;
    end
  end

  assign tos       = tos_q;
  assign nos       = nos_q;
  assign flag_zero = (tos_q == '0);
  assign flag_neg  = tos_q[DW-1];
  assign flag_eq   = (tos_q == nos_q);
  assign flag_lt   = ($signed(nos_q) < $signed(tos_q));

  AST_TOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a_we |=> $stable(tos_q)); // R2
  AST_NOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !b_we |=> $stable(nos_q)); // R3
  AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (b_we && !b_src) |=> nos_q == $past(tos_q)); // R3
  AST_ARITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && !a_src) |=> tos_q == $past(sum)); // R1
endmodule

// File: tb/tb_stk_datapath.sv
module tb_stk_datapath;
  logic clk = 1'b0;
  logic rst_ni;
  logic op_sub, a_src, a_we, b_src, b_we, vp_we, ram_we, ram_wr_dir, ram_rd_dir;
  logic [1:0] log_op, shf_op, reg_src, sp_op;
  logic [2:0] ld_src;
  logic [7:0] ram_dir_addr;
  logic [31:0] io_rdata, tos, nos;
  logic [9:0] bcpc_in;
  logic flag_zero, flag_neg, flag_eq, flag_lt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stk_datapath dut (
    .clk(clk), .rst_ni(rst_ni), .op_sub(op_sub), .a_src(a_src), .a_we(a_we),
    .b_src(b_src), .b_we(b_we), .log_op(log_op), .shf_op(shf_op),
    .ld_src(ld_src), .reg_src(reg_src), .sp_op(sp_op), .vp_we(vp_we),
    .ram_we(ram_we), .ram_wr_dir(ram_wr_dir), .ram_rd_dir(ram_rd_dir),
    .ram_dir_addr(ram_dir_addr), .io_rdata(io_rdata), .bcpc_in(bcpc_in),
    .tos(tos), .nos(nos), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_eq(flag_eq), .flag_lt(flag_lt)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 arith, 1 logic, 2 shift
    logic [1:0]  sel;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd0, 2'd0, 32'd5,          32'd7,          32'd12},
    '{2'd0, 2'd1, 32'd3,          32'd10,         32'd7},
    '{2'd0, 2'd1, 32'd1,          32'd0,          32'hFFFF_FFFF},
    '{2'd0, 2'd0, 32'hFFFF_FFFF,  32'd1,          32'd0},
    '{2'd1, 2'd1, 32'hF0F0_F0F0,  32'hFF00_FF00,  32'hF000_F000},
    '{2'd1, 2'd2, 32'hF0F0_F0F0,  32'hFF00_FF00,  32'hFFF0_FFF0},
    '{2'd1, 2'd3, 32'hF0F0_F0F0,  32'hFF00_FF00,  32'h0FF0_0FF0},
    '{2'd1, 2'd0, 32'hF0F0_F0F0,  32'hFF00_FF00,  32'hFF00_FF00},
    '{2'd2, 2'd0, 32'd4,          32'h8000_0000,  32'h0800_0000},
    '{2'd2, 2'd1, 32'd31,         32'd1,          32'h8000_0000},
    '{2'd2, 2'd2, 32'd4,          32'h8000_0000,  32'hF800_0000},
    '{2'd2, 2'd3, 32'h24,         32'h8000_0000,  32'h0800_0000},
    '{2'd2, 2'd2, 32'd0,          32'h8000_0001,  32'h8000_0001},
    '{2'd1, 2'd3, 32'h55,         32'h55,         32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    op_sub = 0; a_src = 0; a_we = 0; b_src = 0; b_we = 0; vp_we = 0;
    ram_we = 0; ram_wr_dir = 0; ram_rd_dir = 0; log_op = 0; shf_op = 0;
    ld_src = 0; reg_src = 0; sp_op = 0; ram_dir_addr = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic load_a(input logic [31:0] v);
    a_src = 1; a_we = 1; ld_src = 3'd3; io_rdata = v;
    step();
  endtask

  task automatic read_reg(input logic [1:0] which);
    a_src = 1; a_we = 1; ld_src = 3'd4; reg_src = which;
    step();
  endtask

  task automatic set_ab(input logic [31:0] av, input logic [31:0] bv);
    load_a(bv);
    b_we = 1; b_src = 0;
    load_a(av);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    io_rdata = 0; bcpc_in = 0; rst_ni = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 tos reset", tos, 32'd0);
    chk("R13 nos reset", nos, 32'd0);
    rst_ni = 1;
    repeat (3) step();
    chk("R13 flags after reset", {28'd0, flag_zero, flag_neg, flag_eq, flag_lt}, 32'b1010);
    read_reg(2'd0);
    chk("R13 sp start / R7 sp source", tos, 32'd64);
    read_reg(2'd1);
    chk("R13 vp reset / R7 vp source", tos, 32'd0);

    // table of operations
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [3:0] fexp;
      set_ab(v.a, v.b);
      fexp = {v.a == 0, v.a[31], v.a == v.b, $signed(v.b) < $signed(v.a)};
      chk("R9 R10 flags", {28'd0, flag_zero, flag_neg, flag_eq, flag_lt}, {28'd0, fexp});
      a_we = 1;
      if (v.kind == 2'd0) begin
        a_src = 0; op_sub = v.sel[0];
        step(); chk("R1 arith", tos, v.res);
      end else if (v.kind == 2'd1) begin
        a_src = 1; ld_src = 3'd0; log_op = v.sel;
        step(); chk("R4 logic", tos, v.res);
      end else begin
        a_src = 1; ld_src = 3'd1; shf_op = v.sel;
        step(); chk("R5 shift", tos, v.res);
      end
    end

    // unused load code falls back to the logic result
    set_ab(32'h0F, 32'h3C);
    a_src = 1; a_we = 1; ld_src = 3'd6; log_op = 2'd1;
    step(); chk("R6 code 6 logic", tos, 32'h0C);

    // hold when enables are low
    set_ab(32'h1111, 32'h2222);
    a_src = 1; ld_src = 3'd3; io_rdata = 32'hDEAD; b_src = 0;
    step();
    chk("R2 tos hold", tos, 32'h1111);
    chk("R3 nos hold", nos, 32'h2222);

    // bytecode pc zero-extended
    bcpc_in = 10'h3FF;
    read_reg(2'd2);
    chk("R7 pc source", tos, 32'h3FF);

    // variable pointer enable
    load_a(32'h1A5);
    vp_we = 1; step();
    load_a(32'h77);
    step();
    read_reg(2'd1);
    chk("R12 vp load", tos, 32'hA5);

    // stack pointer moves
    sp_op = 2'd3; step();
    read_reg(2'd0);
    chk("R8 sp inc", tos, 32'd65);
    sp_op = 2'd2; step();
    sp_op = 2'd2; step();
    read_reg(2'd0);
    chk("R8 sp dec", tos, 32'd63);
    load_a(32'hF00);
    sp_op = 2'd1; step();
    sp_op = 2'd2; step();
    read_reg(2'd0);
    chk("R8 sp load wrap", tos, 32'hFF);

    // spill and refill through the stack RAM
    load_a(32'h40);
    sp_op = 2'd1; step();
    set_ab(32'h1234, 32'hCAFE);
    ram_we = 1; sp_op = 2'd3; b_we = 1; b_src = 0;
    step();
    chk("R3 push moves tos down", nos, 32'h1234);
    step();
    b_we = 1; b_src = 1; sp_op = 2'd2;
    step();
    chk("R11 pop refills nos", nos, 32'hCAFE);

    // direct write, blocked write, direct read
    set_ab(32'h0, 32'h2222);
    ram_we = 1; ram_wr_dir = 1; ram_dir_addr = 8'h50; step();
    set_ab(32'h0, 32'h1111);
    ram_we = 0; ram_wr_dir = 1; ram_dir_addr = 8'h50; step();
    ram_rd_dir = 1; ram_dir_addr = 8'h50; step();
    a_src = 1; a_we = 1; ld_src = 3'd2; step();
    chk("R11 R6 ram read after blocked write", tos, 32'h2222);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule